// File: doc/BRIEF.md
# Flash Byte Transfer Data Register for a JTAG Port

This block sits behind a JTAG test access port and moves flash bytes one at a time. Everything runs on the test clock. The TAP controller supplies decoded Capture-DR, Shift-DR and Update-DR strobes and a two-bit register select. The block uses these to load a one-bit reset register, a 16-bit enable key and an 8-bit byte register, all through one shared shift path. Data enters on TDI and leaves on TDO, least significant bit first.

Once the key matches and the reset bit is set, each Update-DR on the byte register starts a short sequencer. In write mode it strobes the byte into the page buffer at the current address. In read mode the byte was already captured from the current address. The sequencer then advances the address, and the increment runs freely across page boundaries. An Update-DR that arrives while the sequencer is still busy raises a one-cycle overrun pulse and is dropped. The byte already in progress is not disturbed.

Top module: `jtag_page_dr`

## Requirements
- R1: While reset is held and after it is released, `prog_en`, `busy`, `flash_wr`, `flash_rd` and `overrun` are 0.
- R2: `ir_sel` selects the register: 1 is the reset bit (1 bit), 2 is the enable key (16 bits), 3 is the byte register (8 bits) and 0 is none. Shifting is LSB first. The value loaded at Update-DR is the last N bits shifted in. TDO presents the captured value LSB first, and capturing the key register returns the stored key.
- R3: `prog_en` is 1 exactly when the reset bit is 1 and the stored key equals 16'hA370. A key update is ignored while the reset bit is 0.
- R4: Any other key leaves `prog_en` at 0. Byte-register updates then cause no `flash_wr`, no `busy` and no address change.
- R5: In write mode (`rd_mode`=0), an accepted Update-DR raises `flash_wr` for exactly the one following cycle. During that cycle `flash_addr` is the current address and `flash_wdata` is the shifted byte.
- R6: After an accepted Update-DR, `busy` is high for 10 cycles. The address increments by one as `busy` falls. A following Update-DR 11 or more cycles later is accepted.
- R7: An Update-DR on the byte register while `busy` is high produces `overrun`=1 in the next cycle. It is otherwise ignored: no strobe, no extra increment, and the byte in progress is unchanged.
- R8: In read mode, Capture-DR on the byte register (while idle and enabled) pulses `flash_rd` and captures `flash_rdata` at the current address. The first byte read therefore comes from the start address, and each Update-DR then advances the address.
- R9: Incrementing from the last byte of a page (page = 2*PAGE_WORDS bytes) moves the address to byte 0 of the next page, both for reads and for writes.
- R10: Writing 0 to the reset bit is ignored while the stored key is nonzero. Loading key 0 clears `prog_en`, after which the reset bit can be cleared.
- R11: A high `addr_load` while enabled and idle sets the address to `start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| ir_sel | input | 2 | Register select (0 none, 1 reset bit, 2 key, 3 byte) |
| rd_mode | input | 1 | 1 = read flash, 0 = load page buffer |
| addr_load | input | 1 | Load start address |
| start_addr | input | ADDR_W | Byte address loaded by `addr_load` |
| flash_rdata | input | 8 | Byte at `flash_addr` from the array |
| tdo | output | 1 | Serial data out |
| flash_addr | output | ADDR_W | Current byte address (bit 0 picks the high byte of a word) |
| flash_wdata | output | 8 | Byte being written |
| flash_wr | output | 1 | Page buffer write strobe |
| flash_rd | output | 1 | Array read strobe |
| prog_en | output | 1 | Programming access granted |
| busy | output | 1 | Sequencer active |
| overrun | output | 1 | Update-DR dropped while busy |

## Verification
The assertions assume that `prog_en` does not drop in the middle of a byte operation. They also assume that `addr_load` and the TAP strobes are never asserted together, and that `flash_rdata` settles in the same cycle as `flash_addr`. The stimulus enforces this by never reloading the key during a byte operation and by pulsing `addr_load` only in idle cycles. It also drives one TAP strobe per cycle and uses an address-indexed combinational array model. The only exception to the pacing is a deliberately short two-bit scan that exercises the overrun path. Otherwise, padding of one or twelve idle cycles spaces the byte scans at least 11 cycles apart.

// File: rtl/jpd_pkg.sv
package jpd_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RST  = 2'd1,
    SEL_KEY  = 2'd2,
    SEL_DATA = 2'd3
  } dr_sel_e;

  localparam int          SR_W       = 16;
  localparam int          BYTE_W     = 8;
  localparam logic [15:0] ENABLE_KEY = 16'hA370;
endpackage

// File: rtl/jpd_shreg.sv
module jpd_shreg
  import jpd_pkg::*;
(
  input  logic              tck,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  dr_sel_e           sel,
  input  logic              cap_rst_bit,
  input  logic [SR_W-1:0]   cap_key,
  input  logic              cap_rd_en,
  input  logic [BYTE_W-1:0] cap_rdata,
  output logic [SR_W-1:0]   sr,
  output logic              tdo
);
  logic [SR_W-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = sr_q;
    if (capture) begin
      case (sel)
        SEL_RST:  sr_n = {{(SR_W-1){1'b0}}, cap_rst_bit};
        SEL_KEY:  sr_n = cap_key;
        SEL_DATA: sr_n = {{(SR_W-BYTE_W){1'b0}}, (cap_rd_en ? cap_rdata : {BYTE_W{1'b0}})};
        default:  sr_n = sr_q;
      endcase
    end else if (shift) begin
      sr_n = {tdi, sr_q[SR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign sr  = sr_q;
  assign tdo = sr_q[0];
endmodule

// File: rtl/jpd_gate.sv
module jpd_gate
  import jpd_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            update,
  input  dr_sel_e         sel,
  input  logic [SR_W-1:0] sr,
  output logic            rst_bit,
  output logic [SR_W-1:0] key,
  output logic            prog_en
);
  logic            rbit_q, rbit_n;
  logic [SR_W-1:0] key_q, key_n;
  logic            key_clear;

  assign key_clear = (key_q == '0);

  always_comb begin
    rbit_n = rbit_q;
    key_n  = key_q;
    if (update && sel == SEL_RST && (sr[SR_W-1] || key_clear))
      rbit_n = sr[SR_W-1];
    if (update && sel == SEL_KEY && rbit_q)
      key_n = sr;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      rbit_q <= 1'b0;
      key_q  <= '0;
    end else begin
      rbit_q <= rbit_n;
      key_q  <= key_n;
    end
  end

  assign rst_bit = rbit_q;
  assign key     = key_q;
  assign prog_en = rbit_q && (key_q == ENABLE_KEY);
endmodule

// File: rtl/jpd_seq.sv
module jpd_seq
  import jpd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int SEQ_LEN = 11
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rd_mode,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              wr,
  output logic              busy,
  output logic              overrun
);
  localparam int               CNT_W = $clog2(SEQ_LEN);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SEQ_LEN - 2);

  logic              busy_q, busy_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [BYTE_W-1:0] wdat_q, wdat_n;
  logic              iswr_q, iswr_n;
  logic              ovr_q, ovr_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    wdat_n = wdat_q;
    iswr_n = iswr_q;
    ovr_n  = 1'b0;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        addr_n = addr_q + 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (load) begin
      addr_n = start_addr;
    end
    if (go) begin
      if (busy_q) begin
        ovr_n = 1'b1;
      end else begin
        busy_n = 1'b1;
        cnt_n  = '0;
        iswr_n = !rd_mode;
        wdat_n = byte_in;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      iswr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      wdat_q <= wdat_n;
      iswr_q <= iswr_n;
      ovr_q  <= ovr_n;
    end
  end

  assign addr    = addr_q;
  assign wdata   = wdat_q;
  assign wr      = busy_q && (cnt_q == '0) && iswr_q;
  assign busy    = busy_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/jtag_page_dr.sv
module jtag_page_dr
  import jpd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_WORDS = 128,
  parameter int SEQ_LEN    = 11
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [1:0]        ir_sel,
  input  logic              rd_mode,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        flash_rdata,
  output logic              tdo,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_wdata,
  output logic              flash_wr,
  output logic              flash_rd,
  output logic              prog_en,
  output logic              busy,
  output logic              overrun
);
  localparam int PAGE_BYTES = 2 * PAGE_WORDS;
  localparam int OFF_W      = $clog2(PAGE_BYTES);

  logic [1:0]      rsync;
  logic            rst_q;
  dr_sel_e         sel;
  logic [SR_W-1:0] sr;
  logic            rst_bit;
  logic [SR_W-1:0] key;
  logic            go;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  assign sel      = dr_sel_e'(ir_sel);
  assign flash_rd = capture_dr && (sel == SEL_DATA) && rd_mode && prog_en && !busy;
  assign go       = update_dr && (sel == SEL_DATA) && prog_en;

  jpd_shreg u_shreg (
    .tck(tck), .rst_n(rst_q), .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
    .sel(sel), .cap_rst_bit(rst_bit), .cap_key(key), .cap_rd_en(flash_rd),
    .cap_rdata(flash_rdata), .sr(sr), .tdo(tdo)
  );

  jpd_gate u_gate (
    .tck(tck), .rst_n(rst_q), .update(update_dr), .sel(sel), .sr(sr),
    .rst_bit(rst_bit), .key(key), .prog_en(prog_en)
  );

  jpd_seq #(.ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN)) u_seq (
    .tck(tck), .rst_n(rst_q), .go(go), .rd_mode(rd_mode),
    .byte_in(sr[SR_W-1 -: BYTE_W]), .load(addr_load && prog_en),
    .start_addr(start_addr), .addr(flash_addr), .wdata(flash_wdata),
    .wr(flash_wr), .busy(busy), .overrun(overrun)
  );
endmodule

// File: rtl/jpd_chk.sv
module jpd_chk #(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 8
) (
  input logic              tck,
  input logic              rst_n,
  input logic              rst_q,
  input logic              update_dr,
  input logic [1:0]        ir_sel,
  input logic              prog_en,
  input logic              busy,
  input logic              flash_wr,
  input logic              flash_rd,
  input logic              overrun,
  input logic [ADDR_W-1:0] flash_addr
);
  always_comb begin
    if (!rst_n) AST_QUIET_IN_RESET: assert (!flash_wr && !busy && !overrun); // R1
  end

  AST_EN_FROM_KEY: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    $rose(prog_en) |-> ($past(update_dr) && $past(ir_sel) == 2'd2)); // R3
  AST_WR_GATED: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    flash_wr |-> prog_en); // R4
  AST_WR_PULSE: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    flash_wr |=> !flash_wr); // R5
  AST_INC_ON_DONE: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    $fell(busy) |-> (flash_addr == $past(flash_addr) + 1'b1)); // R6
  AST_NO_OVERRUN_EFFECT: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    (busy && update_dr && ir_sel == 2'd3 && prog_en) |=> (overrun && !flash_wr)); // R7
  AST_RD_IDLE: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    flash_rd |-> !busy); // R8
  AST_PAGE_CROSS: assert property (@(posedge tck) disable iff (!rst_n || !rst_q)
    ($fell(busy) && $past(flash_addr[OFF_W-1:0]) == {OFF_W{1'b1}})
      |-> (flash_addr[OFF_W-1:0] == {OFF_W{1'b0}})); // R9
endmodule

bind jtag_page_dr jpd_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .rst_q(rst_q), .update_dr(update_dr), .ir_sel(ir_sel),
  .prog_en(prog_en), .busy(busy), .flash_wr(flash_wr), .flash_rd(flash_rd),
  .overrun(overrun), .flash_addr(flash_addr)
);

// File: tb/jtag_page_dr_test.sv
module jtag_page_dr_test;
  localparam int ADDR_W = 17;

  logic              tck = 1'b0;
  logic              rst_n;
  logic              capture_dr, shift_dr, update_dr, tdi;
  logic [1:0]        ir_sel;
  logic              rd_mode, addr_load;
  logic [ADDR_W-1:0] start_addr;
  logic [7:0]        flash_rdata;
  logic              tdo;
  logic [ADDR_W-1:0] flash_addr;
  logic [7:0]        flash_wdata;
  logic              flash_wr, flash_rd, prog_en, busy, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [ADDR_W+7:0] exp_q[$];

  always #2.5 tck = ~tck;

  function automatic logic [7:0] model(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = a * 37 + 11;
    return t[7:0];
  endfunction

  assign flash_rdata = model(flash_addr);

  jtag_page_dr uut (
    .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .ir_sel(ir_sel), .rd_mode(rd_mode),
    .addr_load(addr_load), .start_addr(start_addr), .flash_rdata(flash_rdata),
    .tdo(tdo), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
    .flash_wr(flash_wr), .flash_rd(flash_rd), .prog_en(prog_en), .busy(busy),
    .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: every write strobe pops one expected {addr,data}
  always @(negedge tck) begin
    if (rst_n && flash_wr) begin
      if (exp_q.size() == 0) begin
        check("R4/R7 unexpected flash_wr", {15'd0, flash_addr}, 32'hFFFF_FFFF);
      end else begin
        logic [ADDR_W+7:0] e;
        e = exp_q.pop_front();
        check("R5/R9 write addr+data", {7'd0, flash_addr, flash_wdata}, {7'd0, e});
      end
    end
  end

  task automatic scan(input logic [1:0] sel, input int nbits, input logic [15:0] val,
                      input int pad, output logic [15:0] got);
    ir_sel = sel;
    got = '0;
    capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      got[i] = tdo;
      shift_dr = 1'b1;
      tdi = val[i];
      @(negedge tck);
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    repeat (pad) @(negedge tck);
  endtask

  task automatic write_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int pad);
    logic [15:0] g;
    exp_q.push_back({a, d});
    scan(2'd3, 8, {8'd0, d}, pad, g);
  endtask

  task automatic load_addr(input logic [ADDR_W-1:0] a);
    start_addr = a;
    addr_load = 1'b1;
    @(negedge tck);
    addr_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    check("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [15:0] g;
    rst_n = 1'b0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    ir_sel = 2'd0; rd_mode = 0; addr_load = 0; start_addr = '0;
    repeat (3) @(negedge tck);
    check("R1 prog_en in reset", prog_en, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge tck);
    check("R1 strobes after reset", {flash_wr, flash_rd, overrun}, 0);

    // key without reset bit is ignored
    scan(2'd2, 16, 16'hA370, 1, g);
    check("R3 key ignored while reset bit 0", prog_en, 0);
    scan(2'd1, 1, 16'h0001, 1, g);
    scan(2'd2, 16, 16'hA371, 1, g);
    check("R4 wrong key", prog_en, 0);
    scan(2'd3, 8, 16'h00AA, 0, g);
    check("R4 no busy when disabled", busy, 0);
    repeat (12) @(negedge tck);
    scan(2'd2, 16, 16'hA370, 1, g);
    check("R3 correct key enables", prog_en, 1);
    scan(2'd2, 16, 16'hA370, 1, g);
    check("R2 key capture LSB first", g, 16'hA370);

    // writes crossing a page boundary, minimal spacing
    load_addr(17'h000FE);
    write_byte(17'h000FE, 8'hA5, 1);
    write_byte(17'h000FF, 8'h3C, 1);
    write_byte(17'h00100, 8'h0F, 1);
    write_byte(17'h00101, 8'h96, 12);

    // overrun: a short scan during busy
    write_byte(17'h00102, 8'h55, 0);
    scan(2'd3, 2, 16'h0003, 0, g);
    check("R7 overrun flagged", overrun, 1);
    repeat (12) @(negedge tck);
    check("R6 idle after sequence", busy, 0);
    write_byte(17'h00103, 8'h77, 12);

    // reads across a page boundary
    rd_mode = 1'b1;
    load_addr(17'h001FE);
    scan(2'd3, 8, 16'h0000, 12, g);
    check("R8 first read from start address", g[7:0], model(17'h001FE));
    scan(2'd3, 8, 16'h0000, 12, g);
    check("R8 second read", g[7:0], model(17'h001FF));
    scan(2'd3, 8, 16'h0000, 12, g);
    check("R9 read crosses page", g[7:0], model(17'h00200));
    check("R11 address after reads", flash_addr, 17'h00201);
    rd_mode = 1'b0;

    // leaving programming mode
    scan(2'd1, 1, 16'h0000, 1, g);
    check("R10 reset-bit clear ignored while key set", prog_en, 1);
    scan(2'd2, 16, 16'h0000, 1, g);
    check("R10 zero key disables", prog_en, 0);
    scan(2'd1, 1, 16'h0000, 1, g);
    scan(2'd2, 16, 16'hA370, 1, g);
    check("R10 reset bit cleared after key zero", prog_en, 0);

    repeat (4) @(negedge tck);
    check("R5 all expected writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule